// File: doc/BRIEF.md
# Opcode Pair Frequency Profiler

This block observes the opcodes retired by a byte-coded processor, one per cycle at most, and keeps a table of counters with one entry for every ordered pair of consecutive opcodes. The table index is formed from the previously counted opcode in the high half and the current opcode in the low half. Software reads any entry through a simple strobe-and-index port and derives single-opcode totals by summing a row of the table.

A count-enable input lets the host pause profiling around idle or wait loops. A paused stretch does not break a pair: the next counted opcode pairs with the last one counted before the pause. A clear command sweeps the whole table to zero, one entry per cycle, and reports busy while the sweep runs. Reset starts the same sweep. Counters wrap at their width, and a sticky flag records that at least one wrap took place.

The opcode width and the counter width are parameters. The table holds 2^(2*OP_W) entries. The defaults are kept small enough to elaborate quickly. A full byte opcode with 32-bit counters gives the 65536-entry configuration.

Top module: `pairprof_top`

## Requirements
- R1: After reset, `busy` is 1 for exactly 2^(2*OP_W) cycles following the release of reset. When it falls, every table entry reads 0, `ovf` is 0 and `rd_valid` is 0.
- R2: An opcode is counted when `op_valid`=1, `count_en`=1 and `busy`=0 at a rising clock edge. Each counted opcode that follows an earlier counted opcode adds 1 to the entry at index {previous opcode, current opcode}, with the previous opcode in bits [2*OP_W-1:OP_W] and the current opcode in bits [OP_W-1:0].
- R3: The first opcode counted after reset or after a clear changes no entry. It only becomes the previous opcode.
- R4: An opcode offered with `count_en`=0, or any cycle with `op_valid`=0, changes no entry and leaves the previous opcode as it was. The pair therefore spans the gap.
- R5: Back-to-back counted pairs that hit the same index, on consecutive cycles or on every other cycle, are each counted exactly once.
- R6: Entries count modulo 2^CNT_W. `ovf` becomes 1 after an increment wraps an entry from all ones to 0. It then stays 1 until a clear is accepted.
- R7: A `rd_strobe` at one edge makes `rd_valid`=1 after the next edge, with `rd_data` holding the count of entry `rd_idx`. Without a strobe, `rd_valid` is 0 after the next edge.
- R8: A `clr_req` seen with `busy`=0 raises `busy` at the next edge for exactly 2^(2*OP_W) cycles. At the end every entry reads 0 and `ovf` is 0. Opcodes and further `clr_req` pulses that arrive while `busy`=1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; starts a table sweep |
| op_valid | input | 1 | An opcode retires this cycle |
| op_code | input | OP_W | Retired opcode |
| count_en | input | 1 | 1 = count the offered opcode, 0 = skip it |
| clr_req | input | 1 | Start a clearing sweep of the table |
| rd_strobe | input | 1 | Host read request |
| rd_idx | input | 2*OP_W | Host read index {previous, current} |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | CNT_W | Count of the requested entry |
| busy | output | 1 | Clearing sweep in progress |
| ovf | output | 1 | Sticky: some entry has wrapped |

## Verification
The bench runs a small configuration (3-bit opcodes, 6-bit counters) and reads back all 64 entries after each stimulus pattern. It compares them with a table it computes itself.

The stimulus patterns are:
- Every ordered pair driven once in a structured walk. This separates index ordering errors, such as swapped halves, from counting errors.
- Long runs of one opcode and alternating opcodes. These distinguish a correct forwarding path from a lost increment on consecutive or every-other-cycle hits.
- Gaps with `op_valid` low and opcodes offered with `count_en` low. These show whether the previous opcode is held across a pause or wrongly refreshed.
- A run long enough to wrap one counter. This exposes a missing or non-sticky overflow flag.
- A clear during which opcodes and a second clear request arrive. This tells apart a sweep that is shortened or restarted from one that ignores them, and checks that the first opcode afterwards only primes.
- A pseudo-random stream with mixed enables and gaps.

// File: rtl/pairprof_pkg.sv
// Shared types for the opcode pair profiler.
package pairprof_pkg;
    // State of the table-clearing sweep.
    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/pairprof_prev.sv
// Previous-opcode tracker and first pipeline stage.
// Holds the last counted opcode and a "primed" flag. On each counted
// opcode it issues an increment request for {previous, current}, except
// for the first opcode after reset or flush, which only primes the tracker.
// Assumes: accept is already gated by enable and busy.
module pairprof_prev #(
    parameter int OP_W = 4,
    localparam int IDX_W = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             accept,
    input  logic [OP_W-1:0]  op_code,
    output logic             req_v,
    output logic [IDX_W-1:0] req_idx
);
    logic [OP_W-1:0] prev_q;
    logic            primed_q;

    // Track the previous counted opcode and emit stage-1 requests.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
            req_v    <= 1'b0;
            req_idx  <= '0;
        end else begin
            req_v   <= accept && primed_q;
            req_idx <= {prev_q, op_code};
            if (accept) begin
                prev_q   <= op_code;
                primed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pairprof_sweep.sv
// Clearing sweep sequencer.
// Walks every table index once, one per cycle, to write zero. It starts
// on reset and on a clear request seen while idle. Requests made while it
// is running are ignored.
module pairprof_sweep
    import pairprof_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_req,
    output logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] wr_idx
);
    sweep_state_t    state_q;
    logic [IDX_W-1:0] addr_q;

    // A clear is accepted only when no sweep is running.
    assign start  = clr_req && (state_q == SWEEP_IDLE);
    assign busy   = (state_q == SWEEP_RUN);
    assign wr_idx = addr_q;

    // Sequence the sweep address and the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SWEEP_RUN;
            addr_q  <= '0;
        end else if (start) begin
            state_q <= SWEEP_RUN;
            addr_q  <= '0;
        end else if (state_q == SWEEP_RUN) begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == LAST) begin
                state_q <= SWEEP_IDLE;
            end
        end
    end
endmodule

// File: rtl/pairprof_cntmem.sv
// Counter table with a two-cycle read-modify-write increment pipeline.
// Stage 1 reads the table at the requested index. Stage 2 adds one and
// writes back. A one-entry forwarding register covers a stage-2 hit on
// the entry written one edge earlier, whose read returned the old value.
// The host port reads synchronously and takes a same-edge write into
// account. The sweep write has priority over the increment write.
// Assumes: no increment requests arrive while the sweep runs.
module pairprof_cntmem #(
    parameter int IDX_W = 8,
    parameter int CNT_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_v,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             swp_en,
    input  logic [IDX_W-1:0] swp_idx,
    input  logic             rd_strobe,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             wrap
);
    logic [CNT_W-1:0] table_q [DEPTH];
    logic [CNT_W-1:0] old_q;
    logic             s2_v;
    logic [IDX_W-1:0] s2_idx;
    logic             fw_v;
    logic [IDX_W-1:0] fw_idx;
    logic [CNT_W-1:0] fw_data;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] bumped;
    logic             inc_we;

    // Choose the freshest copy of the entry and add one.
    always_comb begin
        base   = (fw_v && (fw_idx == s2_idx)) ? fw_data : old_q;
        bumped = base + 1'b1;
        inc_we = s2_v && !swp_en;
        wrap   = inc_we && (bumped == '0);
    end

    // Table storage: one write port, stage-1 read and host read.
    always_ff @(posedge clk) begin
        if (swp_en) begin
            table_q[swp_idx] <= '0;
        end else if (inc_we) begin
            table_q[s2_idx] <= bumped;
        end
        old_q <= table_q[req_idx];
        if (inc_we && (s2_idx == rd_idx)) begin
            rd_data <= bumped;
        end else begin
            rd_data <= table_q[rd_idx];
        end
    end

    // Pipeline control, forwarding register and read-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s2_v     <= 1'b0;
            s2_idx   <= '0;
            fw_v     <= 1'b0;
            fw_idx   <= '0;
            fw_data  <= '0;
        end else begin
            s2_v    <= req_v;
            s2_idx  <= req_idx;
            fw_v    <= inc_we;
            fw_idx  <= s2_idx;
            fw_data <= bumped;
        end
    end

    // Host read answers one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_strobe;
        end
    end
endmodule

// File: rtl/pairprof_top.sv
// Opcode pair frequency profiler, top level.
// Counts ordered pairs of consecutive counted opcodes in a table indexed
// by {previous, current}. Provides a host read port, a clearing sweep
// with busy, and a sticky wrap flag.
// Assumes: at most one retired opcode per cycle; host reads are only
// meaningful while busy is low.
module pairprof_top #(
    parameter int OP_W  = 4,
    parameter int CNT_W = 32,
    localparam int IDX_W = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic             count_en,
    input  logic             clr_req,
    input  logic             rd_strobe,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             busy,
    output logic             ovf
);
    logic             clr_start;
    logic [IDX_W-1:0] swp_idx;
    logic             accept;
    logic             req_v;
    logic [IDX_W-1:0] req_idx;
    logic             wrap;

    // An opcode counts only when enabled and no sweep runs.
    assign accept = op_valid && count_en && !busy;

    pairprof_sweep #(.IDX_W(IDX_W)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_req (clr_req),
        .start   (clr_start),
        .busy    (busy),
        .wr_idx  (swp_idx)
    );

    pairprof_prev #(.OP_W(OP_W)) u_prev (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (clr_start),
        .accept  (accept),
        .op_code (op_code),
        .req_v   (req_v),
        .req_idx (req_idx)
    );

    pairprof_cntmem #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (clr_start),
        .req_v     (req_v),
        .req_idx   (req_idx),
        .swp_en    (busy),
        .swp_idx   (swp_idx),
        .rd_strobe (rd_strobe),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wrap      (wrap)
    );

    // Sticky wrap flag, cleared by reset and by an accepted clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_start) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/pairprof_chk.sv
// Port-level checker for the pair profiler, bound to every instance.
// Measures the busy window with a counter rather than a long delay.
module pairprof_chk #(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input logic clk,
    input logic rst_n,
    input logic clr_req,
    input logic rd_strobe,
    input logic rd_valid,
    input logic busy,
    input logic ovf
);
    logic [IDX_W:0] blen_q;

    // Count the consecutive cycles for which busy has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else if (busy) begin
            blen_q <= blen_q + 1'b1;
        end else begin
            blen_q <= '0;
        end
    end

    // R1 R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == (IDX_W+1)'(DEPTH)));

    // R8
    clr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !busy) |=> busy);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(clr_req && !busy)) |=> ovf);

    // R7
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);

    // R7
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);
endmodule

bind pairprof_top pairprof_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_req   (clr_req),
    .rd_strobe (rd_strobe),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .ovf       (ovf)
);

// File: tb/pairprof_top_tb.sv
// Self-checking bench: small configuration, full-table readback against
// a table the bench computes itself.
module pairprof_top_tb;
    localparam int CLK_P = 10;
    localparam int OPW   = 3;
    localparam int CW    = 6;
    localparam int IW    = 2 * OPW;
    localparam int DEPTH = 1 << IW;
    localparam int MASK  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [OPW-1:0] op_code = '0;
    logic          count_en = 1'b0;
    logic          clr_req = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [CW-1:0] rd_data;
    logic          busy;
    logic          ovf;

    int vectors = 0;
    int errors  = 0;
    int model [DEPTH];
    logic [OPW-1:0] m_prev = '0;
    bit  m_primed = 1'b0;
    bit  m_ovf = 1'b0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pairprof_top #(.OP_W(OPW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .count_en(count_en), .clr_req(clr_req), .rd_strobe(rd_strobe),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .ovf(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one opcode at a falling edge; update the bench table per R2-R4.
    task automatic send(input logic [OPW-1:0] op, input bit en);
        op_valid = 1'b1;
        op_code  = op;
        count_en = en;
        if (en && !busy) begin
            if (m_primed) begin
                int idx = int'({m_prev, op});
                model[idx] = (model[idx] + 1) & MASK;
                if (model[idx] == 0) m_ovf = 1'b1;
            end
            m_prev   = op;
            m_primed = 1'b1;
        end
        @(negedge clk);
        op_valid = 1'b0;
        count_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Read every entry back and compare it; then check read-valid and ovf.
    task automatic verify_all(input string req);
        idle(4);
        for (int i = 0; i < DEPTH; i++) begin
            rd_strobe = 1'b1;
            rd_idx    = IW'(i);
            @(negedge clk);
            rd_strobe = 1'b0;
            chk("R7 rd_valid", int'(rd_valid), 1);
            chk(req, int'(rd_data), model[i]);
        end
        @(negedge clk);
        chk("R7 rd_valid idle", int'(rd_valid), 0);
        chk("R6 ovf", int'(ovf), int'(m_ovf));
    endtask

    // Count busy cycles, optionally offering opcodes and a second clear.
    task automatic wait_sweep(input string req, input bit poke);
        int n = 0;
        while (busy && n < 4 * DEPTH) begin
            n++;
            if (poke) begin
                op_valid = (n < 10);
                count_en = 1'b1;
                op_code  = OPW'(n);
                clr_req  = (n == 20);
            end
            @(negedge clk);
        end
        op_valid = 1'b0;
        count_en = 1'b0;
        clr_req  = 1'b0;
        chk(req, n, DEPTH);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        idle(3);
        // R1: reset state and sweep length
        chk("R1 rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        wait_sweep("R1 busy length after reset", 1'b0);
        chk("R1 ovf after reset", int'(ovf), 0);
        verify_all("R1 table zero after reset");

        // R2 R3: every ordered pair walked; first opcode only primes
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                send(OPW'(a), 1'b1);
                send(OPW'(b), 1'b1);
            end
        end
        verify_all("R2 exhaustive pair walk");

        // R5: same index back to back and every other cycle
        for (int i = 0; i < 12; i++) send(3'd5, 1'b1);
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 3'd1 : 3'd2, 1'b1);
        verify_all("R5 repeated index");

        // R4: gaps and disabled opcodes keep the previous opcode
        send(3'd3, 1'b1); idle(2); send(3'd4, 1'b0); send(3'd6, 1'b1);
        send(3'd0, 1'b0); idle(3); send(3'd7, 1'b0); send(3'd2, 1'b1);
        verify_all("R4 gaps and disabled opcodes");

        // R6: wrap one counter
        for (int i = 0; i < 70; i++) send(3'd7, 1'b1);
        verify_all("R6 wrap modulo");
        chk("R6 ovf set after wrap", int'(ovf), 1);

        // R8: clear with opcodes and a second clear during busy
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        chk("R8 busy after clear", int'(busy), 1);
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        m_primed = 1'b0;
        m_ovf    = 1'b0;
        wait_sweep("R8 busy length with pokes", 1'b1);
        verify_all("R8 table zero after clear");

        // R3: first opcode after clear only primes
        send(3'd2, 1'b1);
        verify_all("R3 prime only");
        send(3'd3, 1'b1);
        verify_all("R3 first pair after clear");

        // R2 R4 R5: pseudo-random stream with gaps and enables
        begin
            logic [31:0] seed = 32'h1234_5678;
            for (int i = 0; i < 400; i++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                if (seed[22] | seed[23]) send(seed[18:16], seed[20] | seed[21]);
                else idle(1);
            end
        end
        verify_all("R2 random stream");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule